// File: doc/BRIEF.md
# Page-Chained Block Transfer Engine

This block is a single-channel transfer engine that moves words between a peripheral and memory with no processor involvement. Software programs a start word address and a word count, writes a small table of page numbers, and then writes a start command that also selects the direction. While busy, the engine requests the bus. It moves exactly one word in each cycle in which the bus is granted and the peripheral reports itself ready. Between moves it leaves the bus to other masters.

Memory is divided into pages of 256 words, and consecutive pages of one transfer are not assumed to be adjacent. The engine steps the address by one word within a page. When a transfer runs off the end of a page, the next word goes to offset zero of the page named by the next entry of a four-entry chain table. The table is used in order and wraps back to its first entry. When the last word has moved, a done flag is set and the interrupt line is held high until software acknowledges it.

Top module: `dma_pager`

## Requirements
- R1: After reset, busy and done are 0, `irq` and `bus_req` are low, and the status word reads 0.
- R2: A write to offset 2 with bit 1 set starts a transfer. The transfer uses the start address held at offset 0, the count held at offset 1, and the direction given in bit 0 of the same write. `bus_req` is high from the following cycle until the last word has moved.
- R3: A word moves (`mem_en` high) only in a cycle where `bus_gnt` and `per_rdy` are both high. No word moves in any other cycle.
- R4: Within a page, each moved word's address is one greater than the previous word's address.
- R5: After the word at page offset 255, the next word's address is the page number from chain entry i (offset 4+i) followed by eight zero bits. Entries are taken in the order 0,1,2,3 and then from 0 again.
- R6: Direction 0 moves peripheral to memory: `per_rd_en` and `mem_we` pulse, and `mem_wdata` equals `per_rdata`. Direction 1 moves memory to peripheral: `per_wr_en` pulses, `mem_we` stays low, and `per_wdata` equals `mem_rdata`.
- R7: After the last word, busy clears, done sets, and `irq` goes high. The status word at offset 3 holds busy in bit 0, done in bit 1, and the remaining count in bits 31:16, which reads 0 at that point.
- R8: `irq` stays high until a write to offset 3 with bit 1 set, or until a new start command.
- R9: A start with a count of 0 sets done and `irq` in the next cycle and never raises `bus_req`.
- R10: A start command written while busy is ignored. The running transfer keeps its count, address and direction, and the remaining count can be read through the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | Bus request while a transfer is active |
| bus_gnt | input | 1 | Bus grant for this cycle |
| mem_en | output | 1 | Memory access strobe, one word |
| mem_we | output | 1 | Memory write (direction 0) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Data written to memory |
| mem_rdata | input | 32 | Data read from memory, same cycle |
| per_rdy | input | 1 | Peripheral can accept or supply a word |
| per_rd_en | output | 1 | Take one word from the peripheral |
| per_rdata | input | 32 | Word supplied by the peripheral |
| per_wr_en | output | 1 | Give one word to the peripheral |
| per_wdata | output | 32 | Word given to the peripheral |

## Verification
The bound assertions check on every cycle that no word moves without both grant and peripheral readiness, and that each address step is either plus one inside a page or a landing on page offset zero. They also check that the two peripheral strobes are never both active and that the interrupt holds until it is acknowledged. The exact order in which chain entries are used, including the wrap back to entry 0 after four page crossings, can only be shown by the bench's long transfers. The same holds for the total number of words moved, the ignored restart, the zero-count completion, and the status contents.

// File: rtl/dma_pager_pkg.sv
package dma_pager_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 16;
    localparam int PAGE_BITS  = 8;
    localparam int CHAIN_N    = 4;
    localparam int RA_W       = 3;
    localparam int PAGE_NUM_W = ADDR_W - PAGE_BITS;
    localparam int CHAIN_W    = $clog2(CHAIN_N);

    localparam int CTRL_DIR   = 0;
    localparam int CTRL_START = 1;
    localparam int STAT_BUSY  = 0;
    localparam int STAT_DONE  = 1;

    typedef logic [ADDR_W-1:0]     addr_t;
    typedef logic [DATA_W-1:0]     data_t;
    typedef logic [LEN_W-1:0]      len_t;
    typedef logic [PAGE_NUM_W-1:0] page_t;
    typedef logic [CHAIN_W-1:0]    cidx_t;
    typedef logic [CHAIN_N-1:0][PAGE_NUM_W-1:0] chain_t;

    typedef enum logic [RA_W-1:0] {
        REG_START  = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_STATUS = 3'd3,
        REG_CHAIN  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        DIR_P2M = 1'b0,
        DIR_M2P = 1'b1
    } dir_e;

    typedef struct packed {
        addr_t addr;
        len_t  len;
        dir_e  dir;
    } cmd_t;

    function automatic logic page_last(addr_t a);
        return &a[PAGE_BITS-1:0];
    endfunction

    function automatic cidx_t chain_next(cidx_t i);
        return (int'(i) == CHAIN_N - 1) ? '0 : cidx_t'(i + 1'b1);
    endfunction

endpackage

// File: rtl/dma_pager_regs.sv
module dma_pager_regs
    import dma_pager_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  data_t           reg_wdata,
    input  logic            busy,
    input  len_t            rem,
    input  logic            done_set,
    output logic            go,
    output cmd_t            cmd,
    output chain_t          chain,
    output logic            done,
    output data_t           reg_rdata
);

    addr_t  start_q;
    len_t   count_q;
    chain_t chain_q;
    logic   done_q;
    logic   wr_ctrl;
    logic   ack;
    logic   unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:ADDR_W];

    assign wr_ctrl = reg_we && (reg_addr == REG_CTRL);
    assign go      = wr_ctrl && reg_wdata[CTRL_START] && !busy;
    assign ack     = reg_we && (reg_addr == REG_STATUS) && reg_wdata[STAT_DONE];
    assign cmd     = '{addr: start_q, len: count_q, dir: dir_e'(reg_wdata[CTRL_DIR])};
    assign chain   = chain_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (reg_we && reg_addr == REG_START) start_q <= reg_wdata[ADDR_W-1:0];
            if (reg_we && reg_addr == REG_COUNT) count_q <= reg_wdata[LEN_W-1:0];
            if (done_set)         done_q <= 1'b1;
            else if (go || ack)   done_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < CHAIN_N; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst)
                chain_q[i] <= '0;
            else if (reg_we && reg_addr == RA_W'(int'(REG_CHAIN) + i))
                chain_q[i] <= reg_wdata[PAGE_NUM_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr >= REG_CHAIN) begin
            reg_rdata[PAGE_NUM_W-1:0] = chain_q[reg_addr[CHAIN_W-1:0]];
        end else begin
            case (reg_addr)
                REG_START:  reg_rdata[ADDR_W-1:0] = start_q;
                REG_COUNT:  reg_rdata[LEN_W-1:0]  = count_q;
                REG_STATUS: begin
                    reg_rdata[STAT_BUSY]            = busy;
                    reg_rdata[STAT_DONE]            = done_q;
                    reg_rdata[DATA_W-1 -: LEN_W]    = rem;
                end
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_pager_engine.sv
module dma_pager_engine
    import dma_pager_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  cmd_t   cmd,
    input  chain_t chain,
    input  logic   bus_gnt,
    input  logic   per_rdy,
    output logic   busy,
    output len_t   rem,
    output addr_t  cur_addr,
    output dir_e   dir,
    output logic   fire,
    output logic   done_set
);

    logic  busy_q;
    addr_t addr_q;
    len_t  rem_q;
    cidx_t idx_q;
    dir_e  dir_q;
    logic  last_word;

    assign fire      = busy_q && bus_gnt && per_rdy;
    assign last_word = (rem_q == len_t'(1));
    assign done_set  = (go && cmd.len == '0) || (fire && last_word);
    assign busy      = busy_q;
    assign rem       = rem_q;
    assign cur_addr  = addr_q;
    assign dir       = dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            idx_q  <= '0;
            dir_q  <= DIR_P2M;
        end else if (go && cmd.len != '0) begin
            busy_q <= 1'b1;
            addr_q <= cmd.addr;
            rem_q  <= cmd.len;
            idx_q  <= '0;
            dir_q  <= cmd.dir;
        end else if (fire) begin
            rem_q <= rem_q - 1'b1;
            if (last_word) busy_q <= 1'b0;
            if (page_last(addr_q)) begin
                addr_q <= {chain[idx_q], {PAGE_BITS{1'b0}}};
                idx_q  <= chain_next(idx_q);
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_pager_port.sv
module dma_pager_port
    import dma_pager_pkg::*;
(
    input  logic  fire,
    input  dir_e  dir,
    input  data_t mem_rdata,
    input  data_t per_rdata,
    output logic  mem_en,
    output logic  mem_we,
    output logic  per_rd_en,
    output logic  per_wr_en,
    output data_t mem_wdata,
    output data_t per_wdata
);

    assign mem_en    = fire;
    assign mem_we    = fire && (dir == DIR_P2M);
    assign per_rd_en = fire && (dir == DIR_P2M);
    assign per_wr_en = fire && (dir == DIR_M2P);
    assign mem_wdata = per_rdata;
    assign per_wdata = mem_rdata;

endmodule

// File: rtl/dma_pager.sv
module dma_pager
    import dma_pager_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic            irq,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            mem_en,
    output logic            mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic            per_rdy,
    output logic            per_rd_en,
    input  logic [DATA_W-1:0] per_rdata,
    output logic            per_wr_en,
    output logic [DATA_W-1:0] per_wdata
);

    logic   go;
    cmd_t   cmd;
    chain_t chain;
    logic   busy;
    len_t   rem;
    addr_t  cur_addr;
    dir_e   dir;
    logic   fire;
    logic   done_set;
    logic   done;

    dma_pager_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .rem       (rem),
        .done_set  (done_set),
        .go        (go),
        .cmd       (cmd),
        .chain     (chain),
        .done      (done),
        .reg_rdata (reg_rdata)
    );

    dma_pager_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .cmd      (cmd),
        .chain    (chain),
        .bus_gnt  (bus_gnt),
        .per_rdy  (per_rdy),
        .busy     (busy),
        .rem      (rem),
        .cur_addr (cur_addr),
        .dir      (dir),
        .fire     (fire),
        .done_set (done_set)
    );

    dma_pager_port u_port (
        .fire      (fire),
        .dir       (dir),
        .mem_rdata (mem_rdata),
        .per_rdata (per_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .per_rd_en (per_rd_en),
        .per_wr_en (per_wr_en),
        .mem_wdata (mem_wdata),
        .per_wdata (per_wdata)
    );

    assign irq      = done;
    assign bus_req  = busy;
    assign mem_addr = cur_addr;

endmodule

// File: rtl/dma_pager_chk.sv
module dma_pager_chk
    import dma_pager_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            reg_we,
    input logic [RA_W-1:0] reg_addr,
    input logic            wbit1,
    input logic            irq,
    input logic            bus_req,
    input logic            bus_gnt,
    input logic            per_rdy,
    input logic            mem_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic            per_rd_en,
    input logic            per_wr_en,
    input logic            busy
);

    logic ack_or_start;
    assign ack_or_start = reg_we && wbit1 &&
                          (reg_addr == REG_STATUS || reg_addr == REG_CTRL);

    // R3: a word only moves with grant and peripheral ready
    assert_move_needs_grant_R3: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (bus_gnt && per_rdy));

    // R3, R2: nothing moves while the bus is not requested
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_req |-> !mem_en);

    // R4: in-page step is plus one
    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !(&mem_addr[PAGE_BITS-1:0])) |=>
        (!busy || mem_addr == addr_t'($past(mem_addr) + 1'b1)));

    // R5: leaving a page lands on offset zero
    assert_page_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_en && (&mem_addr[PAGE_BITS-1:0])) |=>
        (!busy || mem_addr[PAGE_BITS-1:0] == '0));

    // R6: never both peripheral strobes
    assert_one_dir_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({per_rd_en, per_wr_en}));

    // R8: interrupt holds until acknowledged or restarted
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack_or_start) |=> irq);

endmodule

bind dma_pager dma_pager_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wbit1     (reg_wdata[1]),
    .irq       (irq),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .per_rdy   (per_rdy),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .per_rd_en (per_rd_en),
    .per_wr_en (per_wr_en),
    .busy      (busy)
);

// File: tb/tb_dma_pager.sv
module tb_dma_pager;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 5;
    localparam int WATCHDOG   = 150000;

    // {start address, count, direction, alternate grant}
    localparam logic [33:0] VECS [NVEC] = '{
        {16'h0100, 16'd5,    1'b0, 1'b0},
        {16'h01FE, 16'd4,    1'b1, 1'b1},
        {16'h20FF, 16'd600,  1'b0, 1'b0},
        {16'h00FF, 16'd1100, 1'b1, 1'b1},
        {16'h0010, 16'd1,    1'b1, 1'b0}
    };

    localparam logic [7:0] CHAIN [4] = '{8'h12, 8'h34, 8'h56, 8'h78};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, bus_req, bus_gnt = 1'b0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, per_rdata, per_wdata;
    logic        per_rdy = 1'b0, per_rd_en, per_wr_en;

    int n_tests = 0;
    int n_fail  = 0;

    assign mem_rdata = {16'hC3C3, mem_addr};
    assign per_rdata = {16'h5A5A, ~mem_addr};

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_pager dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .per_rdy(per_rdy), .per_rd_en(per_rd_en),
        .per_rdata(per_rdata), .per_wr_en(per_wr_en), .per_wdata(per_wdata)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Runs the active transfer to its end, checking every moved word.
    task automatic run_xfer(input logic [15:0] a0, input int len, input logic dir,
                            input logic alt, input string tag);
        logic [15:0] a = a0;
        int idx = 0, cnt = 0, addr_bad = 0, dir_bad = 0, gate_bad = 0, cyc = 0;
        while (cnt < len && cyc < 4 * len + 20) begin
            bus_gnt = alt ? cyc[0] : 1'b1;
            per_rdy = 1'b1;
            #1;
            if (mem_en && !bus_gnt) gate_bad++;
            if (mem_en) begin
                if (mem_addr != a) addr_bad++;
                if (dir == 1'b0) begin
                    if (!(mem_we && per_rd_en && !per_wr_en && mem_wdata == {16'h5A5A, ~a}))
                        dir_bad++;
                end else begin
                    if (!(!mem_we && per_wr_en && !per_rd_en && per_wdata == {16'hC3C3, a}))
                        dir_bad++;
                end
                cnt++;
                if (a[7:0] == 8'hFF) begin
                    a = {CHAIN[idx], 8'h00};
                    idx = (idx + 1) % 4;
                end else begin
                    a = a + 16'd1;
                end
            end
            cyc++;
            @(negedge clk);
        end
        bus_gnt = 1'b0;
        #1;
        check(cnt == len, {tag, " R2 word count"}, cnt, len);
        check(addr_bad == 0, {tag, " R4/R5 address sequence"}, addr_bad, 0);
        check(dir_bad == 0, {tag, " R6 direction strobes"}, dir_bad, 0);
        check(gate_bad == 0, {tag, " R3 grant gating"}, gate_bad, 0);
    endtask

    task automatic end_checks(input string tag);
        logic [31:0] s;
        rd(3'd3, s);
        check(irq && !bus_req, {tag, " R7 irq high, bus_req low"}, {irq, bus_req}, 2'b10);
        check(s == 32'h0000_0002, {tag, " R7 status done, remaining 0"}, s, 32'h2);
    endtask

    initial begin : main
        logic [31:0] s;
        int moves;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        rd(3'd3, s);
        check(s == 0 && !irq && !bus_req && !mem_en, "R1 reset state", s, 0);

        for (int i = 0; i < 4; i++) wr(3'(4 + i), {24'h0, CHAIN[i]});

        for (int v = 0; v < NVEC; v++) begin
            wr(3'd0, {16'h0, VECS[v][33:18]});
            wr(3'd1, {16'h0, VECS[v][17:2]});
            wr(3'd2, {30'h0, 1'b1, VECS[v][1]});
            #1 check(bus_req, $sformatf("vec%0d R2 bus_req after start", v), bus_req, 1);
            run_xfer(VECS[v][33:18], int'(VECS[v][17:2]), VECS[v][1], VECS[v][0],
                     $sformatf("vec%0d", v));
            end_checks($sformatf("vec%0d", v));
            wr(3'd3, 32'h2);
            #1 check(!irq, $sformatf("vec%0d R8 ack clears irq", v), irq, 0);
        end

        // R9: zero count
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h2);
        #1 check(irq && !bus_req, "R9 zero count completes at once", {irq, bus_req}, 2'b10);
        @(negedge clk);
        #1 check(irq && !bus_req, "R9 still no bus request", {irq, bus_req}, 2'b10);
        wr(3'd3, 32'h2);

        // R3 stall then R10 ignored restart
        wr(3'd0, 32'h0040);
        wr(3'd1, 32'd10);
        wr(3'd2, 32'h2);            // direction 0
        moves = 0;
        for (int c = 0; c < 6; c++) begin
            bus_gnt = c[0]; per_rdy = ~c[0];
            #1 if (mem_en) moves++;
            @(negedge clk);
        end
        bus_gnt = 1'b0; per_rdy = 1'b0;
        check(moves == 0, "R3 no move without both grant and ready", moves, 0);
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h0900);
        wr(3'd2, 32'h3);            // restart, direction 1: ignored
        rd(3'd3, s);
        check(s == {16'd10, 16'h1}, "R10 remaining kept, still busy", s, {16'd10, 16'h1});
        run_xfer(16'h0040, 10, 1'b0, 1'b0, "restart R10");
        end_checks("restart");

        // R8: new start clears irq
        wr(3'd0, 32'h0300);
        wr(3'd1, 32'd2);
        wr(3'd2, 32'h2);
        #1 check(!irq && bus_req, "R8 new start clears irq", {irq, bus_req}, 2'b01);
        run_xfer(16'h0300, 2, 1'b0, 1'b0, "R8 follow");
        end_checks("R8 follow");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule